// File: doc/BRIEF.md
# Bit-Clock Rate Detector

The block works out which of four supported bit-clock frequencies is driving it, by counting its own clock cycles between successive rising edges of an 8 kHz frame-synchronisation signal. The clock that it counts is the same clock that serves as both the serial data bit clock and the master clock of the surrounding logic, so the ratio of clock cycles to frame period identifies the frequency directly. Nothing has to be configured.

The measured period is compared against four tolerance bands. These are 8.192 MHz (1024 cycles), 4.096 MHz (512), 2.048 MHz (256), and a shared class covering 1.536 MHz and 1.544 MHz (192 or 193 cycles). The band result is then qualified over two consecutive frames before a valid flag is raised. A single stray or missing sync pulse drops the flag. The flag returns once two clean frames have been seen again. Downstream frame-timing and timeout logic reads the encoded rate and uses it only while the flag is high.

Top module: `bclk_rate_detect`

## Requirements
- R1: While reset is asserted and after it is released, `rate_valid` is 0 and `rate` is 2'b00, until frames have been measured.
- R2: A period is the number of clock cycles from one rising edge of `fsync` to the next. The first rising edge after reset only starts a measurement and produces no result.
- R3: A period within 2 cycles of 1024 gives class 2'b00. Within 2 of 512 gives 2'b01. Within 2 of 256 gives 2'b10. Any value from 190 to 195 gives 2'b11.
- R4: `rate_valid` rises only at a frame edge whose period falls in the same class as the period of the frame just before it. Outputs change in the cycle after the edge is sampled.
- R5: A period outside every band clears `rate_valid` at that edge and forgets the previous frame, so two further matching frames are needed to set it again.
- R6: When two consecutive in-band periods fall in different classes, `rate_valid` drops. The next frame of the new class sets it again with the new `rate`.
- R7: The cycle counter stops at 2047 and does not wrap. When it reaches 2047 without a new edge, `rate_valid` clears. A period measured at saturation counts as out of band.
- R8: `rate` changes only at a qualifying frame edge, and it keeps the last qualified class while `rate_valid` is low.
- R9: An `fsync` held high for several cycles counts as one edge. Only the low-to-high transition starts a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit/master clock being identified |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | 8 kHz frame synchronisation, sampled on `clk` |
| rate | output | 2 | Detected class: 00=8.192, 01=4.096, 10=2.048, 11=1.536/1.544 MHz |
| rate_valid | output | 1 | High after two consecutive frames agree on a class |

## Verification
The assertions check these rules on every cycle:
- The counter restarts at one after every edge.
- The counter holds at its ceiling.
- The flag can rise only at a measured edge that lands in a band.
- An out-of-band period or saturation always clears the flag.
- The rate never moves between measured edges.

Only the bench's scenarios can show the following:
- The exact band limits: 190/195, 1022/1026, and their neighbours just outside.
- The two-frame history after a glitch or a class change.
- The saturation timing near 2047 cycles.
- The single counting of a wide sync pulse.

// File: rtl/bcrd_pkg.sv
`timescale 1ns/1ps
package bcrd_pkg;

  typedef enum logic [1:0] {
    RATE_8M192 = 2'b00,
    RATE_4M096 = 2'b01,
    RATE_2M048 = 2'b10,
    RATE_1M5XX = 2'b11
  } rate_e;

  localparam int NUM_CLASSES = 4;

  // True when count c lies inside [lo - tol, hi + tol]
  function automatic logic in_band(input int c, input int lo, input int hi, input int tol);
    return (c >= lo - tol) && (c <= hi + tol);
  endfunction

endpackage

// File: rtl/bcrd_edge.sv
`timescale 1ns/1ps
module bcrd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_in,
  output logic fs_rise
);
  logic fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fs_in;
  end

  assign fs_rise = fs_in & ~fs_q;
endmodule

// File: rtl/bcrd_counter.sv
`timescale 1ns/1ps
module bcrd_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             saturated,
  output logic             armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      count <= CNT_ONE;
      armed <= 1'b1;
    end else if (count != CNT_MAX) begin
      count <= count + CNT_ONE;
    end
  end

  assign saturated = (count == CNT_MAX);
endmodule

// File: rtl/bcrd_classify.sv
`timescale 1ns/1ps
module bcrd_classify
  import bcrd_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int TOL     = 2,
  parameter int NOM_8M  = 1024,
  parameter int NOM_4M  = 512,
  parameter int NOM_2M  = 256,
  parameter int NOM_1LO = 192,
  parameter int NOM_1HI = 193
) (
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output rate_e            cls
);
  localparam int LO [NUM_CLASSES] = '{NOM_8M, NOM_4M, NOM_2M, NOM_1LO};
  localparam int HI [NUM_CLASSES] = '{NOM_8M, NOM_4M, NOM_2M, NOM_1HI};

  logic [NUM_CLASSES-1:0] match;

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_band
    assign match[k] = in_band(int'(count), LO[k], HI[k], TOL);
  end

  always_comb begin
    hit = 1'b0;
    cls = RATE_8M192;
    for (int k = 0; k < NUM_CLASSES; k++) begin
      if (match[k]) begin
        hit = 1'b1;
        cls = rate_e'(2'(k));
      end
    end
  end
endmodule

// File: rtl/bcrd_qualify.sv
`timescale 1ns/1ps
module bcrd_qualify
  import bcrd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  meas,
  input  logic  hit,
  input  rate_e cls,
  input  logic  timeout,
  output rate_e rate,
  output logic  valid
);
  logic  hist_ok;
  rate_e hist_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_ok  <= 1'b0;
      hist_cls <= RATE_8M192;
      rate     <= RATE_8M192;
      valid    <= 1'b0;
    end else if (timeout) begin
      hist_ok <= 1'b0;
      valid   <= 1'b0;
    end else if (meas) begin
      if (!hit) begin
        hist_ok <= 1'b0;
        valid   <= 1'b0;
      end else begin
        hist_ok  <= 1'b1;
        hist_cls <= cls;
        if (hist_ok && (hist_cls == cls)) begin
          valid <= 1'b1;
          rate  <= cls;
        end else begin
          valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bclk_rate_detect.sv
`timescale 1ns/1ps
module bclk_rate_detect
  import bcrd_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int TOL     = 2,
  parameter int NOM_8M  = 1024,
  parameter int NOM_4M  = 512,
  parameter int NOM_2M  = 256,
  parameter int NOM_1LO = 192,
  parameter int NOM_1HI = 193
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync,
  output logic [1:0] rate,
  output logic       rate_valid
);
  // Named internal events, visible to the bound checker
  logic             frame_edge;
  logic             armed;
  logic             meas_evt;
  logic             cnt_sat;
  logic             band_hit;
  logic [CNT_W-1:0] cnt;
  rate_e            band_cls;
  rate_e            rate_q;

  bcrd_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_in   (fsync),
    .fs_rise (frame_edge)
  );

  bcrd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (frame_edge),
    .count     (cnt),
    .saturated (cnt_sat),
    .armed     (armed)
  );

  bcrd_classify #(
    .CNT_W(CNT_W), .TOL(TOL), .NOM_8M(NOM_8M), .NOM_4M(NOM_4M),
    .NOM_2M(NOM_2M), .NOM_1LO(NOM_1LO), .NOM_1HI(NOM_1HI)
  ) u_cls (
    .count (cnt),
    .hit   (band_hit),
    .cls   (band_cls)
  );

  assign meas_evt = frame_edge & armed;

  bcrd_qualify u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .meas    (meas_evt),
    .hit     (band_hit),
    .cls     (band_cls),
    .timeout (cnt_sat),
    .rate    (rate_q),
    .valid   (rate_valid)
  );

  assign rate = rate_q;
endmodule

// File: rtl/bclk_rate_detect_chk.sv
`timescale 1ns/1ps
module bclk_rate_detect_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_edge,
  input logic             meas_evt,
  input logic             band_hit,
  input logic             cnt_sat,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       rate,
  input logic             rate_valid
);
  // R2: an edge restarts the period count at one
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (cnt == CNT_W'(1)));

  // R4: the flag rises only after a measured in-band edge
  a_r4_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_valid) |-> $past(meas_evt && band_hit));

  // R5: an out-of-band measurement clears the flag
  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_evt && !band_hit) |=> !rate_valid);

  // R7: the counter stays at its ceiling until an edge arrives
  a_r7_sat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sat && !frame_edge) |=> cnt_sat);

  // R7: saturation clears the flag
  a_r7_sat_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sat |=> !rate_valid);

  // R8: the rate moves only after a measured edge
  a_r8_rate_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_evt |=> $stable(rate));
endmodule

bind bclk_rate_detect bclk_rate_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_edge (frame_edge),
  .meas_evt   (meas_evt),
  .band_hit   (band_hit),
  .cnt_sat    (cnt_sat),
  .cnt        (cnt),
  .rate       (rate),
  .rate_valid (rate_valid)
);

// File: tb/bclk_rate_detect_test.sv
`timescale 1ns/1ps
module bclk_rate_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic [1:0] rate;
  logic       rate_valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bclk_rate_detect uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .rate       (rate),
    .rate_valid (rate_valid)
  );

  // {period in cycles, expected valid, expected rate code}
  localparam int NV = 20;
  localparam int VEC [NV][3] = '{
    '{1024, 0, 0},  // R2 first full period, no history yet
    '{1024, 1, 0},  // R4 two frames agree
    '{1026, 1, 0},  // R3 upper edge of 8.192 band
    '{1022, 1, 0},  // R3 lower edge of 8.192 band
    '{1027, 0, 0},  // R5 just outside band
    '{1023, 0, 0},  // R5 history was cleared
    '{1024, 1, 0},
    '{512,  0, 0},  // R6 class change, R8 rate held
    '{510,  1, 1},  // R3 4.096 band
    '{514,  1, 1},
    '{256,  0, 1},  // R8 rate held while invalid
    '{258,  1, 2},  // R3 2.048 band
    '{192,  0, 2},
    '{193,  1, 3},  // R3 1.536/1.544 class
    '{195,  1, 3},
    '{190,  1, 3},
    '{189,  0, 3},  // R5 below shared band
    '{196,  0, 3},  // R5 above shared band
    '{194,  0, 3},
    '{192,  1, 3}
  };

  task automatic check(input string req, input logic [1:0] exp_r, input logic exp_v, input bit chk_rate);
    checks++;
    if (rate_valid !== exp_v || (chk_rate && rate !== exp_r)) begin
      errors++;
      $display("FAIL %s: valid=%0b rate=%0d, expected valid=%0b rate=%0d",
               req, rate_valid, rate, exp_v, exp_r);
    end
  endtask

  task automatic rise(input int w);
    fsync = 1'b1;
    repeat (w) @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 in reset", 2'b00, 1'b0, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", 2'b00, 1'b0, 1'b1);

    // R2: arming edge
    rise(1);
    check("R2 arming edge", 2'b00, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      repeat (VEC[i][0] - 1) @(negedge clk);
      rise(1);
      check($sformatf("R3/R4 vector %0d period %0d", i, VEC[i][0]),
            2'(VEC[i][2]), VEC[i][1] != 0, 1'b1);
    end

    // R7: saturation with no further edge (valid at 3 held now)
    repeat (2040) @(negedge clk);
    check("R7 before ceiling", 2'b11, 1'b1, 1'b1);
    repeat (12) @(negedge clk);
    check("R7 after ceiling", 2'b11, 1'b0, 1'b1);
    rise(1);
    check("R7 saturated period out of band", 2'b11, 1'b0, 1'b1);
    repeat (1023) @(negedge clk);
    rise(1);
    repeat (1023) @(negedge clk);
    rise(1);
    check("R7 recovery after saturation", 2'b00, 1'b1, 1'b1);

    // R9: wide sync pulses counted once
    repeat (511) @(negedge clk);
    rise(6);
    check("R9 wide pulse first", 2'b00, 1'b0, 1'b1);
    repeat (506) @(negedge clk);
    rise(6);
    check("R9 wide pulse confirm", 2'b01, 1'b1, 1'b1);

    // R5: a glitch pulse mid-frame drops the flag
    repeat (200) @(negedge clk);
    rise(1);
    check("R5 glitch drops flag", 2'b01, 1'b0, 1'b1);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 2'b00, 1'b0, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule